// File: doc/BRIEF.md
# Fractional Rate Tick Generator

The block emits a train of one-clock ticks whose long-run frequency equals a programmable number of hertz. It keeps a signed phase accumulator whose modulus is the master clock frequency, so the rate word is simply the wanted tick frequency in Hz. The tick frequency works out to Fclk times rate divided by the modulus, with at most one master-clock period of jitter on any single tick.

Each cycle the accumulator either steps down by the rate, or wraps. When its value is negative, the modulus is added and a wrap flag is set; that flag is the tick output. The wrap cycle takes no rate step. To make up for it, the cycle that follows subtracts twice the rate, formed by a one-bit shift. The datapath therefore needs one adder and a three-way operand select, and never a second adder to form the modulus minus the rate. The rate word is sampled afresh on every cycle. Rates above half the clock are not supported.

Top module: `frac_tick_gen`

## Requirements
- R1: Starting from reset with a constant rate M, the number of ticks over K×CLK_HZ clock cycles is within one of K×M.
- R2: When the accumulator is negative at a clock edge, that edge adds CLK_HZ to it and sets the tick, so tick is 1 in the following cycle.
- R3: In the cycle after a tick, the next edge subtracts twice the rate word and clears the tick.
- R4: On every other edge the accumulator drops by the rate word and tick is 0; with a rate of zero, no tick is ever produced.
- R5: A synchronous reset (rst = 1) clears the accumulator and the tick, so tick is 0 in the cycle after any reset edge.
- R6: For rates in the range 0 to CLK_HZ/2, two ticks are never high on adjacent cycles.
- R7: The rate word is sampled on every edge; a change takes effect at the very next edge, with no restart of the accumulator.
- R8: For rates up to CLK_HZ/2, the accumulator stays between −2·2^RATE_W and CLK_HZ−1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, frequency CLK_HZ |
| rst | input | 1 | Synchronous reset, active high |
| rate | input | RATE_W | Wanted tick frequency in Hz, unsigned |
| tick | output | 1 | One-clock tick pulse |

## Verification
The assertions take for granted that the rate word never exceeds half of CLK_HZ. Without that bound the cycle after a wrap could itself go negative far enough to break the adjacency and range properties. The stimulus keeps every rate, including the values it switches to mid-run, between zero and exactly CLK_HZ/2, with that upper bound driven on purpose. The bench shrinks CLK_HZ so that whole multi-second windows fit in a short run.

// File: rtl/frac_tick_gen.sv
module frac_tick_gen #(
  parameter int CLK_HZ = 50_000_000,
  parameter int RATE_W = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int NW    = $clog2(CLK_HZ + 1);
  localparam int ACC_W = ((NW > RATE_W + 1) ? NW : RATE_W + 1) + 1;

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] step_one;
  logic signed [ACC_W-1:0] step_two;
  logic signed [ACC_W-1:0] modulus;
  logic signed [ACC_W-1:0] addend;

  assign step_one = -signed'(ACC_W'(rate));
  assign step_two = step_one <<< 1;
  assign modulus  = ACC_W'(CLK_HZ);

  always_comb begin
    if (acc[ACC_W-1])  addend = modulus;
    else if (tick)     addend = step_two;
    else               addend = step_one;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      tick <= 1'b0;
    end else begin
      acc  <= acc + addend;
      tick <= acc[ACC_W-1];
    end
  end
endmodule

// File: rtl/frac_tick_gen_chk.sv
module frac_tick_gen_chk #(
  parameter int CLK_HZ = 50_000_000,
  parameter int RATE_W = 25,
  parameter int ACC_W  = 27
) (
  input logic                    clk,
  input logic                    rst,
  input logic [RATE_W-1:0]       rate,
  input logic                    tick,
  input logic signed [ACC_W-1:0] acc
);
  localparam logic signed [ACC_W-1:0] HI = ACC_W'(CLK_HZ - 1);
  localparam logic signed [ACC_W-1:0] LO = -(ACC_W'(1) <<< (RATE_W + 1));

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_q) begin
      a_r5_reset_clear: assert (acc == '0 && !tick)
        else $error("reset did not clear state");
    end
  end

  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    acc < 0 |=> tick && acc == $past(acc) + ACC_W'(CLK_HZ));

  a_r3_double_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick && acc == $past(acc) - (signed'(ACC_W'($past(rate))) <<< 1));

  a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
    (acc >= 0 && !tick) |=> !tick && acc == $past(acc) - signed'(ACC_W'($past(rate))));

  a_r6_no_adjacent: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  a_r8_range: assert property (@(posedge clk) disable iff (rst)
    acc <= HI && acc >= LO);
endmodule

bind frac_tick_gen frac_tick_gen_chk #(
  .CLK_HZ(CLK_HZ), .RATE_W(RATE_W), .ACC_W(ACC_W)
) chk_i (.clk(clk), .rst(rst), .rate(rate), .tick(tick), .acc(acc));

// File: tb/frac_tick_gen_tb_top.sv
module frac_tick_gen_tb_top;
  localparam int N = 1000;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] rate = '0;
  logic tick;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  frac_tick_gen #(.CLK_HZ(N), .RATE_W(W)) dut_i (
    .clk(clk), .rst(rst), .rate(rate), .tick(tick));

  always #5 clk = ~clk;

  // reference built from R2..R5: signed accumulator with wrap flag
  int  m_acc  = 0;
  bit  m_flag = 1'b0;
  bit  exp_q[$];
  always @(posedge clk) begin
    if (rst) begin
      m_acc = 0; m_flag = 1'b0;
    end else if (m_acc < 0) begin
      m_acc = m_acc + N; m_flag = 1'b1;
    end else if (m_flag) begin
      m_acc = m_acc - 2 * int'(rate); m_flag = 1'b0;
    end else begin
      m_acc = m_acc - int'(rate);
    end
    exp_q.push_back(m_flag);
  end

  // monitor: compare every cycle against the scoreboard queue (R2, R3, R4, R7)
  int  seq_fail = 0;
  int  adj_seen = 0;
  int  tick_cnt = 0;
  bit  prev_tick = 1'b0;
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      tests++;
      if (tick !== e) begin
        fails++;
        seq_fail++;
        $display("FAIL R2/R3/R4 sequence: tick=%0b expected %0b at %0t", tick, e, $time);
      end
    end
    if (tick === 1'b1 && prev_tick === 1'b1) adj_seen++;
    if (tick === 1'b1) tick_cnt++;
    prev_tick = tick;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(tick == 1'b0, "R5 tick after reset", tick, 0);
    rst = 1'b0;
  endtask

  task automatic window(input int m, input int k);
    int d;
    do_reset();
    rate = W'(m);
    tick_cnt = 0;
    adj_seen = 0;
    repeat (k * N) @(negedge clk);
    #1;
    d = tick_cnt - k * m;
    check(d >= -1 && d <= 1, "R1 tick count", tick_cnt, k * m);
    check(adj_seen == 0, "R6 adjacent ticks", adj_seen, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check(tick == 1'b0, "R5 reset state", tick, 0);
    rst = 1'b0;

    window(1, 3);
    window(3, 2);
    window(333, 2);
    window(N / 2, 2);
    window(499, 1);
    window(7, 4);

    // R4: zero rate never ticks
    window(0, 2);
    check(tick_cnt == 0, "R4 zero rate", tick_cnt, 0);

    // R7: rate changes mid-run, no restart; sequence checked by scoreboard
    do_reset();
    rate = W'(250);
    repeat (37) @(negedge clk);
    rate = W'(11);
    repeat (123) @(negedge clk);
    rate = W'(N / 2);
    repeat (61) @(negedge clk);
    rate = W'(0);
    repeat (20) @(negedge clk);
    rate = W'(400);
    repeat (300) @(negedge clk);

    // R5: reset in the middle of activity
    rate = W'(480);
    repeat (9) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(tick == 1'b0, "R5 mid-run reset", tick, 0);
    rst = 1'b0;
    repeat (50) @(negedge clk);

    check(seq_fail == 0, "R7 sequence mismatches", seq_fail, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule